// File: doc/BRIEF.md
# Flash erase command sequencer

This block starts page-erase and mass-erase cycles on an on-chip flash array. A processor reaches it through a small register bus. It holds a page-address register, a mass-erase enable register, a write-only command register and a status register. An erase begins only when the processor writes an exact key byte to the command register. Each key also needs an earlier arming write to its own register, and one erase uses that arming up.

When a command is accepted, the block sends the flash array a one-cycle request. The request carries the erase kind and the page number. The block then stays busy until the array answers with a done pulse. A mass erase also needs the debug-enable input to be high when the key is written. Each register is reached at a fixed address on a two-bit bus, and reads are combinational from the address.

Top module: `flash_erase_seq`

## Requirements
- R1: After synchronous reset (`rst` high), the page register reads 0x00, the enable register (address 1) reads 0x00, the status register (address 3) reads 0x00 and `erase_req` is low.
- R2: A write to the page register (address 0) keeps only bits 6:0. Reads of address 0 return that 7-bit page with bit 7 at zero.
- R3: Writing 0x55 to the command register (address 2) while the page arming is set gives `erase_req` high for exactly one cycle. It rises in the cycle after the write, with `erase_mass` low and `erase_page` equal to the page register.
- R4: A write of 0x55 is rejected, with no request, when the page register has not been written since reset or since the last accepted page erase. An accepted page erase clears the page arming.
- R5: Writing 0xAA to the command register gives a one-cycle request with `erase_mass` high. This happens only when the mass arming is set and `dbg_en` is high in the write cycle.
- R6: A write of 0xAA with `dbg_en` low or the mass arming clear gives no request. Any rejected key write (0x55 or 0xAA) clears the mass arming.
- R7: A command write of any value other than 0x55 or 0xAA has no effect. It gives no request and leaves both armings unchanged.
- R8: Status bit 0 (busy) is set from the cycle after an accepted command until the cycle after `erase_done`. While busy, `erase_page` and `erase_mass` hold steady even if the page register is rewritten.
- R9: Command writes that arrive while busy are ignored. They give no request and consume no arming.
- R10: Address 2 always reads 0x00.
- R11: The mass arming is cleared once a mass erase starts. Bit 0 of a write to address 1 sets or clears it, and address 1 reads the arming in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 page, 1 enable, 2 command, 3 status) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| dbg_en | input | 1 | Debug enable, needed for mass erase |
| erase_req | output | 1 | One-cycle erase request to the flash array |
| erase_mass | output | 1 | High for mass erase, low for page erase |
| erase_page | output | 7 | Page number of the current erase |
| erase_done | input | 1 | Flash array reports that the erase has finished |

## Verification
The assertions assume the flash array raises `erase_done` only while the block is busy. They also assume the bus makes at most one register write per cycle. The bench's flash model pulses done for a single cycle only after it has seen a request. The bench drives every bus access as one write strobe between falling edges, so two writes never share a cycle.

// File: rtl/fe_pkg.sv
package fe_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int PAGE_W_DEF = 7;

    typedef enum logic [ADDR_W-1:0] {
        RA_PAGE = 2'd0,
        RA_MEEN = 2'd1,
        RA_CMD  = 2'd2,
        RA_STAT = 2'd3
    } reg_addr_e;

    localparam logic [DATA_W-1:0] KEY_PAGE = 8'h55;
    localparam logic [DATA_W-1:0] KEY_MASS = 8'hAA;

    typedef enum logic [1:0] {
        CK_NONE = 2'd0,
        CK_PAGE = 2'd1,
        CK_MASS = 2'd2
    } cmd_kind_e;

    typedef struct packed {
        logic start;
        logic mass;
        logic reject;
    } cmd_verdict_t;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_BUSY = 1'b1
    } seq_state_e;

    function automatic cmd_kind_e classify_key(input logic [DATA_W-1:0] v);
        if (v == KEY_PAGE)      return CK_PAGE;
        else if (v == KEY_MASS) return CK_MASS;
        else                    return CK_NONE;
    endfunction

endpackage

// File: rtl/fe_regs.sv
module fe_regs
    import fe_pkg::*;
#(
    parameter int PAGE_W = PAGE_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                busy,
    input  cmd_verdict_t        verdict,
    output logic [PAGE_W-1:0]   page_q,
    output logic                page_armed,
    output logic                mass_armed,
    output logic [DATA_W-1:0]   rdata
);
    localparam int PAD_W = DATA_W - PAGE_W;

    logic page_we, meen_we;
    assign page_we = we && (reg_addr_e'(addr) == RA_PAGE);
    assign meen_we = we && (reg_addr_e'(addr) == RA_MEEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q     <= '0;
            page_armed <= 1'b0;
            mass_armed <= 1'b0;
        end else begin
            if (page_we) begin
                page_q     <= wdata[PAGE_W-1:0];
                page_armed <= 1'b1;
            end else if (verdict.start && !verdict.mass) begin
                page_armed <= 1'b0;
            end
            if (meen_we) begin
                mass_armed <= wdata[0];
            end else if ((verdict.start && verdict.mass) || verdict.reject) begin
                mass_armed <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (reg_addr_e'(addr))
            RA_PAGE: rdata = {{PAD_W{1'b0}}, page_q};
            RA_MEEN: rdata = {{(DATA_W-1){1'b0}}, mass_armed};
            RA_CMD:  rdata = '0;
            RA_STAT: rdata = {{(DATA_W-1){1'b0}}, busy};
            default: rdata = '0;
        endcase
    end

    // R11: a mass erase start leaves the mass arming cleared
    p_mass_consumed_r11: assert property (@(posedge clk) disable iff (rst)
        (verdict.start && verdict.mass && !meen_we) |=> !mass_armed);

    // R4: a page erase start consumes the page arming
    p_page_consumed_r4: assert property (@(posedge clk) disable iff (rst)
        (verdict.start && !verdict.mass) |=> !page_armed);

endmodule

// File: rtl/fe_cmd_decode.sv
module fe_cmd_decode
    import fe_pkg::*;
(
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                busy,
    input  logic                page_armed,
    input  logic                mass_armed,
    input  logic                dbg_en,
    output cmd_verdict_t        verdict
);
    logic      cmd_we;
    cmd_kind_e kind;
    logic      ok_page, ok_mass;

    assign cmd_we  = we && (reg_addr_e'(addr) == RA_CMD) && !busy;
    assign kind    = classify_key(wdata);
    assign ok_page = (kind == CK_PAGE) && page_armed;
    assign ok_mass = (kind == CK_MASS) && mass_armed && dbg_en;

    always_comb begin
        verdict.start  = cmd_we && (ok_page || ok_mass);
        verdict.mass   = ok_mass;
        verdict.reject = cmd_we && (kind != CK_NONE) && !(ok_page || ok_mass);
    end

endmodule

// File: rtl/fe_seq.sv
module fe_seq
    import fe_pkg::*;
#(
    parameter int PAGE_W = PAGE_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  cmd_verdict_t        verdict,
    input  logic [PAGE_W-1:0]   page_in,
    input  logic                done,
    output logic                busy,
    output logic                req,
    output logic                mass,
    output logic [PAGE_W-1:0]   page_out
);
    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            req      <= 1'b0;
            mass     <= 1'b0;
            page_out <= '0;
        end else begin
            req <= 1'b0;
            unique case (state)
                SQ_IDLE: if (verdict.start) begin
                    state    <= SQ_BUSY;
                    req      <= 1'b1;
                    mass     <= verdict.mass;
                    page_out <= page_in;
                end
                SQ_BUSY: if (done) state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign busy = (state == SQ_BUSY);

    // R3: request lasts a single cycle
    p_req_single_r3: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);

    // R9: a new request never starts out of a busy cycle
    p_no_req_from_busy_r9: assert property (@(posedge clk) disable iff (rst)
        req |-> !$past(busy));

    // R8: page and kind hold while the erase is in progress
    p_hold_while_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !req && $past(busy)) |-> ($stable(page_out) && $stable(mass)));

    // R8: busy drops only after done
    p_busy_until_done_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done));

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import fe_pkg::*;
#(
    parameter int PAGE_W = PAGE_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic                dbg_en,
    output logic                erase_req,
    output logic                erase_mass,
    output logic [PAGE_W-1:0]   erase_page,
    input  logic                erase_done
);
    cmd_verdict_t       verdict;
    logic               busy;
    logic [PAGE_W-1:0]  page_q;
    logic               page_armed, mass_armed;

    fe_regs #(.PAGE_W(PAGE_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .busy       (busy),
        .verdict    (verdict),
        .page_q     (page_q),
        .page_armed (page_armed),
        .mass_armed (mass_armed),
        .rdata      (reg_rdata)
    );

    fe_cmd_decode u_dec (
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .busy       (busy),
        .page_armed (page_armed),
        .mass_armed (mass_armed),
        .dbg_en     (dbg_en),
        .verdict    (verdict)
    );

    fe_seq #(.PAGE_W(PAGE_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .verdict  (verdict),
        .page_in  (page_q),
        .done     (erase_done),
        .busy     (busy),
        .req      (erase_req),
        .mass     (erase_mass),
        .page_out (erase_page)
    );

    // R5: a mass request needs debug enable in the write cycle
    p_mass_needs_dbg_r5: assert property (@(posedge clk) disable iff (rst)
        (erase_req && erase_mass) |-> $past(dbg_en));

    // R10: command address never returns data
    p_cmd_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_e'(reg_addr) == RA_CMD) |-> (reg_rdata == '0));

endmodule

// File: tb/tb_flash_erase_seq.sv
`timescale 1ns/1ps
module tb_flash_erase_seq;
    logic       clk = 1'b0;
    logic       rst;
    logic       reg_we;
    logic [1:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       dbg_en;
    logic       erase_req, erase_mass, erase_done;
    logic [6:0] erase_page;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    flash_erase_seq dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_en(dbg_en),
        .erase_req(erase_req), .erase_mass(erase_mass),
        .erase_page(erase_page), .erase_done(erase_done)
    );

    localparam logic [1:0] A_PAGE = 2'd0, A_MEEN = 2'd1, A_CMD = 2'd2, A_STAT = 2'd3;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        erase_done = 1'b1;
        @(negedge clk);
        erase_done = 1'b0;
    endtask

    task automatic expect_req(input string tag, input bit mass, input int page);
        logic [7:0] s;
        check(erase_req == 1'b1, tag, erase_req, 1);
        check(erase_mass == mass, tag, erase_mass, mass);
        if (!mass) check(erase_page == page[6:0], tag, erase_page, page);
        rd(A_STAT, s);
        check(s == 8'h01, {tag, " busy"}, s, 1);
        @(negedge clk);
        check(erase_req == 1'b0, {tag, " one-cycle"}, erase_req, 0);
    endtask

    task automatic expect_none(input string tag);
        logic [7:0] s;
        check(erase_req == 1'b0, tag, erase_req, 0);
        rd(A_STAT, s);
        check(s == 8'h00, {tag, " idle"}, s, 0);
    endtask

    task automatic finish_erase(input string tag);
        logic [7:0] s;
        pulse_done();
        rd(A_STAT, s);
        check(s == 8'h00, {tag, " busy clears"}, s, 0);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(A_PAGE, v); check(v == 8'h00, "R1 page", v, 0);
        rd(A_MEEN, v); check(v == 8'h00, "R1 enable", v, 0);
        rd(A_STAT, v); check(v == 8'h00, "R1 status", v, 0);
        check(erase_req == 1'b0, "R1 req", erase_req, 0);
        wr(A_CMD, 8'h55);
        expect_none("R4 unarmed after reset");
    endtask

    task automatic t_page_erase();
        logic [7:0] v;
        wr(A_PAGE, 8'h93);
        rd(A_PAGE, v); check(v == 8'h13, "R2 mask", v, 8'h13);
        wr(A_CMD, 8'h55);
        expect_req("R3 page erase", 1'b0, 8'h13);
        wr(A_PAGE, 8'h05);
        check(erase_page == 7'h13, "R8 page stable", erase_page, 8'h13);
        check(erase_mass == 1'b0, "R8 kind stable", erase_mass, 0);
        finish_erase("R8");
        wr(A_CMD, 8'h55);
        expect_req("R3 rearmed page", 1'b0, 8'h05);
        finish_erase("R8");
        wr(A_CMD, 8'h55);
        expect_none("R4 consumed arming");
    endtask

    task automatic t_mass();
        logic [7:0] v;
        wr(A_MEEN, 8'h01);
        rd(A_MEEN, v); check(v == 8'h01, "R11 enable set", v, 1);
        dbg_en = 1'b0;
        wr(A_CMD, 8'hAA);
        expect_none("R6 no debug");
        rd(A_MEEN, v); check(v == 8'h00, "R6 reject clears", v, 0);
        dbg_en = 1'b1;
        wr(A_CMD, 8'hAA);
        expect_none("R6 unarmed");
        wr(A_MEEN, 8'h01);
        wr(A_CMD, 8'hAA);
        expect_req("R5 mass erase", 1'b1, 0);
        rd(A_MEEN, v); check(v == 8'h00, "R11 consumed", v, 0);
        finish_erase("R8");
        wr(A_MEEN, 8'h01);
        wr(A_CMD, 8'h55);
        expect_none("R6 page key rejected");
        rd(A_MEEN, v); check(v == 8'h00, "R6 page reject clears", v, 0);
    endtask

    task automatic t_other_values();
        logic [7:0] v;
        wr(A_MEEN, 8'h01);
        wr(A_PAGE, 8'h07);
        wr(A_CMD, 8'h12); expect_none("R7 0x12");
        wr(A_CMD, 8'h00); expect_none("R7 0x00");
        wr(A_CMD, 8'h54); expect_none("R7 0x54");
        wr(A_CMD, 8'hAB); expect_none("R7 0xAB");
        rd(A_MEEN, v); check(v == 8'h01, "R7 mass arming kept", v, 1);
        wr(A_CMD, 8'h55);
        expect_req("R7 page arming kept", 1'b0, 8'h07);
        finish_erase("R8");
    endtask

    task automatic t_busy_ignore();
        logic [7:0] v;
        wr(A_CMD, 8'hAA);
        expect_req("R9 setup mass", 1'b1, 0);
        wr(A_PAGE, 8'h09);
        wr(A_CMD, 8'h55);
        expect_none_busy("R9 ignored while busy");
        finish_erase("R9");
        wr(A_CMD, 8'h55);
        expect_req("R9 arming not consumed", 1'b0, 8'h09);
        finish_erase("R9");
        wr(A_CMD, 8'h77);
        rd(A_CMD, v); check(v == 8'h00, "R10 cmd reads zero", v, 0);
    endtask

    task automatic expect_none_busy(input string tag);
        logic [7:0] s;
        check(erase_req == 1'b0, tag, erase_req, 0);
        rd(A_STAT, s);
        check(s == 8'h01, {tag, " still busy"}, s, 1);
    endtask

    initial begin
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        dbg_en = 1'b1; erase_done = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_page_erase();
        t_mass();
        t_other_values();
        t_busy_ignore();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule